// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block receives configuration words over a write-only three-wire port (serial clock, serial data, latch enable) and keeps a small bank of configuration registers whose contents drive the clock distribution logic. The three serial lines are asynchronous to the system clock. Each line passes through a two-stage synchronizer. A rising edge is detected by comparing the synchronized sample with the sample registered one cycle earlier.

Each rising serial-clock edge shifts one data bit into a 32-bit shift register, most significant bit first. A rising edge on latch enable transfers the shifted word to one register. The low four bits of the word name the register, and the upper 28 bits are the value written. A one-cycle strobe, together with the address, reports every write that is committed. The lines rest low when the port is idle.

Top module: `serial_cfg_loader`

## Requirements
- R1: Bits are taken one per rising edge of `ser_clk` and enter the shift register most significant bit first, so the first bit sent ends up as word bit 31, which is register data bit 27.
- R2: In the shifted 32-bit word, bits [3:0] are the register address and bits [31:4] are the value written to that register.
- R3: Rising edges of `ser_clk` that are seen while `ser_latch` is high do not shift the register.
- R4: A write is committed only on a rising edge of `ser_latch`. If the first system clock edge that samples `ser_latch` high is counted as edge 1, the register output changes after edge 3. At no other time does a register output change.
- R5: A word whose address is `NUM_REGS` or greater (default 8 to 15) changes no register and produces no strobe.
- R6: Reset is asynchronous and active low. It loads register i with `DEF_BASE + i` (default base 0x0000100) and clears `wr_pulse`.
- R7: `wr_pulse` is high for exactly one cycle for each committed write. In that cycle `wr_addr` holds the address that was written.
- R8: When more than 32 bits are shifted before the latch, only the last 32 bits are kept.
- R9: If `ser_latch` stays high for many cycles, there is still only one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch enable; a rising edge commits the word |
| cfg_regs | output | NUM_REGS*(WORD_W-ADDR_W) | Register i at bits [i*28 +: 28] |
| wr_pulse | output | 1 | One-cycle strobe for each committed write |
| wr_addr | output | ADDR_W | Address of the most recent committed write |

## Verification
The assertions check four things on every cycle:
- Outputs never change except in a strobe cycle.
- The strobe never lasts two cycles.
- A strobe always carries a mapped address and follows a sampled high on latch enable.
- The shift register is frozen while latch enable is high.

Some behaviour is visible only in the bench scenarios: the bit order, the field split, the exact commit latency, truncation of overlong words and suppression of unmapped addresses. The bench shows these by comparing against a pin-level reference model on every clock and by directed checks on values.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 8,
  parameter logic [WORD_W-ADDR_W-1:0] DEF_BASE = 'h100
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ser_clk,
  input  logic                                 ser_dat,
  input  logic                                 ser_latch,
  output logic [NUM_REGS*(WORD_W-ADDR_W)-1:0]  cfg_regs,
  output logic                                 wr_pulse,
  output logic [ADDR_W-1:0]                    wr_addr
);
  localparam int DATA_W = WORD_W - ADDR_W;

  logic [2:0]        sclk_q, slat_q;
  logic [1:0]        sdat_q;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      slat_q <= '0;
      sdat_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], ser_clk};
      slat_q <= {slat_q[1:0], ser_latch};
      sdat_q <= {sdat_q[0], ser_dat};
    end

  wire               sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire               lat_rise  = slat_q[1] & ~slat_q[2];
  wire               shift_en  = sclk_rise & ~slat_q[1];
  wire  [ADDR_W-1:0] addr      = shreg[ADDR_W-1:0];
  wire               hit       = 32'(addr) < NUM_REGS;
  wire               commit    = lat_rise & hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        shreg <= '0;
    else if (shift_en) shreg <= {shreg[WORD_W-2:0], sdat_q[1]};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           val <= DEF_BASE + DATA_W'(g);
      else if (commit && addr == ADDR_W'(g)) val <= shreg[WORD_W-1:ADDR_W];
    assign cfg_regs[g*DATA_W +: DATA_W] = val;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
    end else begin
      wr_pulse <= commit;
      if (commit) wr_addr <= addr;
    end

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |-> $stable(cfg_regs)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R7
  AST_PULSE_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> 32'(wr_addr) < NUM_REGS); // R5
  AST_PULSE_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> slat_q[2]); // R4
  AST_SHIFT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    slat_q[1] |=> $stable(shreg)); // R3
endmodule

// File: tb/sim_serial_cfg_loader.sv
`timescale 1ns/1ps
module sim_serial_cfg_loader;
  localparam int NR = 8;
  localparam int DW = 28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
  logic [NR*DW-1:0] cfg_regs;
  logic wr_pulse;
  logic [3:0] wr_addr;

  int vectors = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_cfg_loader u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_latch(ser_latch), .cfg_regs(cfg_regs), .wr_pulse(wr_pulse), .wr_addr(wr_addr));

  // pin-level reference model
  bit [DW-1:0] m_regs [NR];
  bit [31:0] m_sh;
  bit m_pulse;
  bit [3:0] m_addr;
  bit hs[$], hd[$], hl[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) m_regs[i] = 28'h100 + DW'(i);
      m_sh = 0; m_pulse = 0; m_addr = 0;
      hs = '{0, 0, 0, 0}; hd = '{0, 0, 0, 0}; hl = '{0, 0, 0, 0};
    end else begin
      hs.push_front(ser_clk); hd.push_front(ser_dat); hl.push_front(ser_latch);
      void'(hs.pop_back()); void'(hd.pop_back()); void'(hl.pop_back());
      m_pulse = 0;
      if (hl[2] && !hl[3] && m_sh[3:0] < NR) begin
        m_regs[m_sh[3:0]] = m_sh[31:4];
        m_pulse = 1;
        m_addr = m_sh[3:0];
      end
      if (hs[2] && !hs[3] && !hl[2]) m_sh = {m_sh[30:0], hd[2]};
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    vectors++;
    for (int i = 0; i < NR; i++)
      if (cfg_regs[i*DW +: DW] !== m_regs[i]) begin
        errors++;
        $display("FAIL R4 reg%0d act=%h exp=%h", i, cfg_regs[i*DW +: DW], m_regs[i]);
      end
    if (wr_pulse !== m_pulse) begin
      errors++;
      $display("FAIL R7 pulse act=%b exp=%b", wr_pulse, m_pulse);
    end
    if (m_pulse && wr_addr !== m_addr) begin
      errors++;
      $display("FAIL R7 addr act=%0d exp=%0d", wr_addr, m_addr);
    end
    if (wr_pulse) pulses++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] reg_of(input int i);
    return cfg_regs[i*DW +: DW];
  endfunction

  task automatic put_bit(input bit b);
    @(negedge clk); ser_dat = b; ser_clk = 1'b0;
    repeat (3) @(negedge clk); ser_clk = 1'b1;
    repeat (3) @(negedge clk); ser_clk = 1'b0;
  endtask

  task automatic send(input logic [63:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
    @(negedge clk); ser_dat = 1'b0;
  endtask

  task automatic latch(input int hold);
    @(negedge clk); ser_latch = 1'b1;
    repeat (hold) @(negedge clk);
    ser_latch = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic write(input logic [3:0] a, input logic [DW-1:0] d);
    send({32'h0, d, a}, 32);
    latch(4);
  endtask

  initial begin
    int p0;
    logic [DW-1:0] old;
    repeat (3) @(negedge clk);
    // R6 reset defaults
    for (int i = 0; i < NR; i++) chk(reg_of(i) === 28'h100 + DW'(i), "R6 reset", 32'(reg_of(i)), 32'(28'h100 + i));
    chk(wr_pulse === 1'b0, "R6 pulse", 32'(wr_pulse), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 MSB first
    send(32'h8000_0001, 32); latch(4);
    chk(reg_of(1) === 28'h8000000, "R1 msb first", 32'(reg_of(1)), 32'h8000000);

    // R2 field split
    write(4'h0, 28'hABCDEF1);
    chk(reg_of(0) === 28'hABCDEF1, "R2 field", 32'(reg_of(0)), 32'hABCDEF1);

    // R4 latency
    send(32'h1234_5673, 32);
    old = reg_of(3);
    p0 = pulses;
    @(negedge clk); ser_latch = 1'b1;
    @(negedge clk); chk(reg_of(3) === old, "R4 early1", 32'(reg_of(3)), 32'(old));
    @(negedge clk); chk(reg_of(3) === old, "R4 early2", 32'(reg_of(3)), 32'(old));
    @(negedge clk); chk(reg_of(3) === 28'h1234567, "R4 commit", 32'(reg_of(3)), 32'h1234567);
    chk(wr_pulse === 1'b1 && wr_addr === 4'd3, "R7 strobe", {wr_pulse, 27'd0, wr_addr}, {1'b1, 27'd0, 4'd3});
    @(negedge clk); chk(wr_pulse === 1'b0, "R7 one cycle", 32'(wr_pulse), 0);
    ser_latch = 1'b0; repeat (5) @(negedge clk);

    // R3 clock edges during latch high ignored
    write(4'h2, 28'h5A5A5A5);
    p0 = pulses;
    @(negedge clk); ser_latch = 1'b1; ser_dat = 1'b1;
    for (int i = 0; i < 4; i++) begin
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (3) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (3) @(negedge clk); ser_latch = 1'b0; ser_dat = 1'b0;
    repeat (5) @(negedge clk);
    latch(4);
    chk(pulses - p0 == 2, "R3 ignored edges", 32'(pulses - p0), 2);
    chk(reg_of(2) === 28'h5A5A5A5, "R3 reg", 32'(reg_of(2)), 32'h5A5A5A5);

    // R5 unmapped address
    p0 = pulses;
    send({32'h0, 28'hFFFFFFF, 4'hC}, 32); latch(4);
    chk(pulses == p0, "R5 no strobe", 32'(pulses - p0), 0);
    chk(reg_of(0) === 28'hABCDEF1 && reg_of(2) === 28'h5A5A5A5, "R5 unchanged", 32'(reg_of(0)), 32'hABCDEF1);

    // R8 overlong word
    send({24'h0, 8'hFF, 28'h0C0FFEE, 4'h5}, 40); latch(4);
    chk(reg_of(5) === 28'h0C0FFEE, "R8 last 32", 32'(reg_of(5)), 32'h0C0FFEE);

    // R9 long latch
    p0 = pulses;
    send({32'h0, 28'h7654321, 4'h6}, 32); latch(40);
    chk(pulses - p0 == 1, "R9 single write", 32'(pulses - p0), 1);
    chk(reg_of(6) === 28'h7654321, "R9 value", 32'(reg_of(6)), 32'h7654321);

    // R2 every register
    for (int i = 0; i < NR; i++) write(4'(i), 28'h0F00000 | DW'(i * 28'h11111));
    for (int i = 0; i < NR; i++)
      chk(reg_of(i) === (28'h0F00000 | DW'(i * 28'h11111)), "R2 all regs", 32'(reg_of(i)), 32'(28'h0F00000 | DW'(i * 28'h11111)));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule